// File: doc/BRIEF.md
# Power Domain Switch Controller

This block switches a small set of on-chip power domains on and off under software control. Software writes one bit per domain into a control word. A set bit asks for the domain to go dark and a cleared bit asks for it to come back. Each domain has its own sequencer. It drives that domain's power-switch enable and its isolation clamp. It waits a programmable settling count in each direction and only then reports the new state in a status word, where a set bit means off.

Settling counts come in a pair per domain group: one for going down and one for coming up, in adjacent words. There is a core group and a graphics group, and a parameter mask decides which group each domain belongs to. Some domains have no power switch at all. For those the control bit is not writable, their switch and isolation pins stay inactive, and their status bit reports the interconnect idle indication supplied on an input. All registers sit behind a simple synchronous host port. Read data appears one cycle after the request.

Top module: `pwr_domain_ctrl`

## Requirements
- R1: After reset, the control word reads 0 and switched domains have the switch enable at 1, isolation at 0 and status 0 (on). All four settling counts read 24.
- R2: When a switched domain's control bit is set, isolation rises on the cycle after the write takes effect, and the switch enable falls one cycle after that, so isolation always leads.
- R3: After the switch enable falls, the domain's status bit (bit i of the status word, 1 = off) becomes 1 exactly down-count + 1 cycles later.
- R4: When the control bit is cleared on an off domain, the switch enable rises on the cycle after the write takes effect. The status bit returns to 0 exactly up-count + 1 cycles later, and isolation drops one cycle after the status bit shows on.
- R5: The core group's down count is at byte offset 0x34 and its up count is at 0x38. The graphics group's down count is at 0x3c and its up count is at 0x40. Each reads back what was written (low 16 bits), and each domain uses its own group's pair.
- R6: For a domain without a switch (domain 3 by default), writes to its control bit are ignored and the bit reads 0. Its switch enable and isolation stay 0, and its status bit follows its bus_idle input.
- R7: A control change that arrives while a domain is mid-transition does not cut that transition short. It is applied on the cycle after the transition completes.
- R8: The control word is at offset 0x08, the read-only status word is at 0x0c (writes ignored) and a read-only mirror of bus_idle is at 0x14. Unmapped offsets read 0, and read data is valid on the cycle after the request.
- R9: A switched domain never has its switch enable at 0 while its isolation is 0.

Ports:

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| host_valid | input | 1 | Register access request |
| host_write | input | 1 | 1 = write, 0 = read |
| host_addr | input | ADDR_W | Byte offset of the register |
| host_wdata | input | DATA_W | Write data |
| host_rdata | output | DATA_W | Read data, one cycle after the request |
| bus_idle | input | NUM_DOM | Per-domain interconnect idle indication |
| sw_en | output | NUM_DOM | Per-domain power-switch enable (1 = powered) |
| iso | output | NUM_DOM | Per-domain isolation clamp (1 = clamped) |

## Verification
The assertions assume that reset is held for at least one clock edge before any access. They also assume that bus_idle is only meaningful for domains without a switch, so no property ties it to the switched sequencers. The stimulus always drives the host port on the falling edge and holds each request for exactly one cycle. Random control words are written at random spacing, including in the middle of transitions, and bus_idle changes only between accesses. Settling counts are kept small during the random phase so every domain reaches its final state within the wait that precedes each check.

// File: rtl/pdc_pkg.sv
package pdc_pkg;

  typedef enum logic [2:0] {
    ST_ON      = 3'd0,
    ST_DN_ISO  = 3'd1,
    ST_DN_WAIT = 3'd2,
    ST_OFF     = 3'd3,
    ST_UP_WAIT = 3'd4,
    ST_UP_REL  = 3'd5
  } dom_state_e;

  localparam int unsigned OFS_CTRL     = 'h08;
  localparam int unsigned OFS_STATUS   = 'h0c;
  localparam int unsigned OFS_IDLE     = 'h14;
  localparam int unsigned OFS_CORE_CNT = 'h34;
  localparam int unsigned OFS_GFX_CNT  = 'h3c;

  localparam int unsigned NUM_CNT = 4;

  // Entry k: bit 1 picks the group (0 core, 1 graphics), bit 0 the direction
  // (0 down, 1 up). The up count sits one word above the down count.
  function automatic int unsigned cnt_ofs(input int unsigned k);
    int unsigned base;
    base = ((k >> 1) != 0) ? OFS_GFX_CNT : OFS_CORE_CNT;
    return base + 4 * (k & 1);
  endfunction

endpackage

// File: rtl/pdc_regs.sv
module pdc_regs #(
  parameter int unsigned NUM_DOM = 4,
  parameter int unsigned ADDR_W  = 8,
  parameter int unsigned DATA_W  = 32,
  parameter int unsigned CNT_W   = 16,
  parameter int unsigned CNT_RST = 24,
  parameter logic [NUM_DOM-1:0] SW_MASK = '1
) (
  input  logic                    clk,
  input  logic                    rst,
  input  logic                    host_valid,
  input  logic                    host_write,
  input  logic [ADDR_W-1:0]       host_addr,
  input  logic [DATA_W-1:0]       host_wdata,
  output logic [DATA_W-1:0]       host_rdata,
  input  logic [NUM_DOM-1:0]      dom_off,
  input  logic [NUM_DOM-1:0]      bus_idle,
  output logic [NUM_DOM-1:0]      ctrl_q,
  output logic [pdc_pkg::NUM_CNT-1:0][CNT_W-1:0] cnt_q
);
  import pdc_pkg::*;

  localparam logic [ADDR_W-1:0] A_CTRL   = ADDR_W'(OFS_CTRL);
  localparam logic [ADDR_W-1:0] A_STATUS = ADDR_W'(OFS_STATUS);
  localparam logic [ADDR_W-1:0] A_IDLE   = ADDR_W'(OFS_IDLE);
  localparam logic [CNT_W-1:0]  CNT_INIT = CNT_W'(CNT_RST);

  logic wr_go, rd_go;
  logic [DATA_W-1:0] rd_val;

  assign wr_go = host_valid &&  host_write;
  assign rd_go = host_valid && !host_write;

  // Control word: bits of domains without a switch are never stored.
  always_ff @(posedge clk) begin
    if (rst) begin
      ctrl_q <= '0;
    end else if (wr_go && host_addr == A_CTRL) begin
      ctrl_q <= host_wdata[NUM_DOM-1:0] & SW_MASK;
    end
  end

  // Settling counts, one register per group and direction.
  for (genvar k = 0; k < NUM_CNT; k++) begin : g_cnt
    localparam logic [ADDR_W-1:0] A_CNT = ADDR_W'(cnt_ofs(k));
    always_ff @(posedge clk) begin
      if (rst) begin
        cnt_q[k] <= CNT_INIT;
      end else if (wr_go && host_addr == A_CNT) begin
        cnt_q[k] <= host_wdata[CNT_W-1:0];
      end
    end
  end

  always_comb begin
    rd_val = '0;
    if (host_addr == A_CTRL)   rd_val[NUM_DOM-1:0] = ctrl_q;
    if (host_addr == A_STATUS) rd_val[NUM_DOM-1:0] = dom_off;
    if (host_addr == A_IDLE)   rd_val[NUM_DOM-1:0] = bus_idle;
    for (int k = 0; k < NUM_CNT; k++) begin
      if (host_addr == ADDR_W'(cnt_ofs(k))) rd_val[CNT_W-1:0] = cnt_q[k];
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      host_rdata <= '0;
    end else if (rd_go) begin
      host_rdata <= rd_val;
    end else begin
      host_rdata <= '0;
    end
  end

endmodule

// File: rtl/pdc_domain.sv
module pdc_domain #(
  parameter int unsigned CNT_W = 16
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             want_off,
  input  logic [CNT_W-1:0] dn_cnt,
  input  logic [CNT_W-1:0] up_cnt,
  output logic             sw_en,
  output logic             iso,
  output logic             off_st
);
  import pdc_pkg::*;

  dom_state_e       st;
  logic [CNT_W-1:0] cnt;

  // Requests are sampled only in the two settled states, so a change that
  // lands mid-transition waits until the sequence finishes.
  always_ff @(posedge clk) begin
    if (rst) begin
      st     <= ST_ON;
      cnt    <= '0;
      sw_en  <= 1'b1;
      iso    <= 1'b0;
      off_st <= 1'b0;
    end else begin
      case (st)
        ST_ON: begin
          if (want_off) begin
            st  <= ST_DN_ISO;
            iso <= 1'b1;
          end
        end
        ST_DN_ISO: begin
          st    <= ST_DN_WAIT;
          sw_en <= 1'b0;
          cnt   <= dn_cnt;
        end
        ST_DN_WAIT: begin
          if (cnt == '0) begin
            st     <= ST_OFF;
            off_st <= 1'b1;
          end else begin
            cnt <= cnt - 1'b1;
          end
        end
        ST_OFF: begin
          if (!want_off) begin
            st    <= ST_UP_WAIT;
            sw_en <= 1'b1;
            cnt   <= up_cnt;
          end
        end
        ST_UP_WAIT: begin
          if (cnt == '0) begin
            st     <= ST_UP_REL;
            off_st <= 1'b0;
          end else begin
            cnt <= cnt - 1'b1;
          end
        end
        ST_UP_REL: begin
          st  <= ST_ON;
          iso <= 1'b0;
        end
        default: st <= ST_ON;
      endcase
    end
  end

endmodule

// File: rtl/pwr_domain_ctrl.sv
module pwr_domain_ctrl #(
  parameter int unsigned NUM_DOM = 4,
  parameter int unsigned ADDR_W  = 8,
  parameter int unsigned DATA_W  = 32,
  parameter int unsigned CNT_W   = 16,
  parameter int unsigned CNT_RST = 24,
  parameter logic [NUM_DOM-1:0] NOSW_MASK = 4'b1000,
  parameter logic [NUM_DOM-1:0] GFX_MASK  = 4'b0100
) (
  input  logic               clk,
  input  logic               rst,
  input  logic               host_valid,
  input  logic               host_write,
  input  logic [ADDR_W-1:0]  host_addr,
  input  logic [DATA_W-1:0]  host_wdata,
  output logic [DATA_W-1:0]  host_rdata,
  input  logic [NUM_DOM-1:0] bus_idle,
  output logic [NUM_DOM-1:0] sw_en,
  output logic [NUM_DOM-1:0] iso
);
  import pdc_pkg::*;

  localparam logic [NUM_DOM-1:0] SW_MASK = ~NOSW_MASK;

  logic [NUM_DOM-1:0] ctrl_q;
  logic [NUM_DOM-1:0] dom_off;
  logic [NUM_CNT-1:0][CNT_W-1:0] cnt_q;

  pdc_regs #(
    .NUM_DOM (NUM_DOM),
    .ADDR_W  (ADDR_W),
    .DATA_W  (DATA_W),
    .CNT_W   (CNT_W),
    .CNT_RST (CNT_RST),
    .SW_MASK (SW_MASK)
  ) u_regs (
    .clk        (clk),
    .rst        (rst),
    .host_valid (host_valid),
    .host_write (host_write),
    .host_addr  (host_addr),
    .host_wdata (host_wdata),
    .host_rdata (host_rdata),
    .dom_off    (dom_off),
    .bus_idle   (bus_idle),
    .ctrl_q     (ctrl_q),
    .cnt_q      (cnt_q)
  );

  for (genvar i = 0; i < NUM_DOM; i++) begin : g_dom
    if (NOSW_MASK[i]) begin : g_noswitch
      assign sw_en[i]   = 1'b0;
      assign iso[i]     = 1'b0;
      assign dom_off[i] = bus_idle[i];
    end else begin : g_switch
      localparam int unsigned GRP = GFX_MASK[i] ? 2 : 0;
      pdc_domain #(
        .CNT_W (CNT_W)
      ) u_dom (
        .clk      (clk),
        .rst      (rst),
        .want_off (ctrl_q[i]),
        .dn_cnt   (cnt_q[GRP]),
        .up_cnt   (cnt_q[GRP+1]),
        .sw_en    (sw_en[i]),
        .iso      (iso[i]),
        .off_st   (dom_off[i])
      );
    end
  end

endmodule

// File: rtl/pwr_domain_ctrl_chk.sv
module pwr_domain_ctrl_chk #(
  parameter int unsigned NUM_DOM = 4,
  parameter logic [NUM_DOM-1:0] NOSW_MASK = '0
) (
  input logic               clk,
  input logic               rst,
  input logic [NUM_DOM-1:0] sw_en,
  input logic [NUM_DOM-1:0] iso,
  input logic [NUM_DOM-1:0] dom_off,
  input logic [NUM_DOM-1:0] ctrl_q
);
  for (genvar i = 0; i < NUM_DOM; i++) begin : g_chk
    if (!NOSW_MASK[i]) begin : g_sw
      // R9
      iso_guard_chk: assert property (@(posedge clk) disable iff (rst)
        !sw_en[i] |-> iso[i]);
      // R2
      iso_lead_chk: assert property (@(posedge clk) disable iff (rst)
        $fell(sw_en[i]) |-> $past(iso[i]));
      // R4
      iso_release_chk: assert property (@(posedge clk) disable iff (rst)
        $fell(iso[i]) |-> (sw_en[i] && $past(!dom_off[i] && sw_en[i])));
      // R3
      off_dark_chk: assert property (@(posedge clk) disable iff (rst)
        $rose(dom_off[i]) |-> (!sw_en[i] && $past(!sw_en[i])));
    end else begin : g_nosw
      // R6
      nosw_ctrl_chk: assert property (@(posedge clk) disable iff (rst)
        !ctrl_q[i]);
    end
  end
endmodule

bind pwr_domain_ctrl pwr_domain_ctrl_chk #(
  .NUM_DOM   (NUM_DOM),
  .NOSW_MASK (NOSW_MASK)
) u_chk (
  .clk     (clk),
  .rst     (rst),
  .sw_en   (sw_en),
  .iso     (iso),
  .dom_off (dom_off),
  .ctrl_q  (ctrl_q)
);

// File: tb/pwr_domain_ctrl_test.sv
module pwr_domain_ctrl_test;
  localparam int NUM  = 4;
  localparam logic [3:0] NOSW = 4'b1000;
  localparam logic [3:0] GFX  = 4'b0100;
  localparam logic [3:0] SWM  = ~NOSW;
  localparam logic [7:0] A_CTRL = 8'h08, A_STAT = 8'h0c, A_IDLE = 8'h14;
  localparam logic [7:0] A_CDN = 8'h34, A_CUP = 8'h38, A_GDN = 8'h3c, A_GUP = 8'h40;

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic host_valid = 1'b0, host_write = 1'b0;
  logic [7:0]  host_addr = '0;
  logic [31:0] host_wdata = '0;
  logic [31:0] host_rdata;
  logic [3:0]  bus_idle = '0;
  logic [3:0]  sw_en, iso;

  int checks = 0, fails = 0;
  bit done = 1'b0;
  logic [3:0] ctrl_sh = '0;
  int cdn = 24, cup = 24, gdn = 24, gup = 24;

  always #2 clk = ~clk;

  pwr_domain_ctrl uut (
    .clk(clk), .rst(rst), .host_valid(host_valid), .host_write(host_write),
    .host_addr(host_addr), .host_wdata(host_wdata), .host_rdata(host_rdata),
    .bus_idle(bus_idle), .sw_en(sw_en), .iso(iso)
  );

  function automatic logic [31:0] exp_sw(input logic [3:0] c);
    return {28'd0, ~c & SWM};
  endfunction
  function automatic logic [31:0] exp_iso(input logic [3:0] c);
    return {28'd0, c & SWM};
  endfunction
  function automatic logic [31:0] exp_stat(input logic [3:0] c, input logic [3:0] idl);
    return {28'd0, (c & SWM) | (idl & NOSW)};
  endfunction

  task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic idle();
    @(negedge clk);
  endtask

  task automatic wr(input logic [7:0] a, input logic [31:0] d);
    host_valid = 1'b1; host_write = 1'b1; host_addr = a; host_wdata = d;
    @(negedge clk);
    host_valid = 1'b0; host_write = 1'b0;
  endtask

  task automatic rd(input logic [7:0] a, output logic [31:0] d);
    host_valid = 1'b1; host_write = 1'b0; host_addr = a;
    @(negedge clk);
    d = host_rdata;
    host_valid = 1'b0;
  endtask

  // Power-down sequence with settling count c, timing checked cycle by cycle.
  task automatic run_down(input int d, input int c);
    logic [31:0] r;
    ctrl_sh[d] = 1'b1;
    wr(A_CTRL, {28'd0, ctrl_sh});
    check("R2 sw_en held on write cycle", 32'(sw_en[d]), 32'd1);
    idle();
    check("R2 iso rises first", 32'(iso[d]), 32'd1);
    check("R2 sw_en still high", 32'(sw_en[d]), 32'd1);
    idle();
    check("R2 sw_en falls after iso", 32'(sw_en[d]), 32'd0);
    repeat (c) idle();
    rd(A_STAT, r);
    check("R3 status still on before count ends", 32'(r[d]), 32'd0);
    rd(A_STAT, r);
    check("R3 status off after count", 32'(r[d]), 32'd1);
  endtask

  task automatic run_up(input int d, input int c);
    logic [31:0] r;
    ctrl_sh[d] = 1'b0;
    wr(A_CTRL, {28'd0, ctrl_sh});
    check("R4 sw_en low on write cycle", 32'(sw_en[d]), 32'd0);
    idle();
    check("R4 sw_en rises", 32'(sw_en[d]), 32'd1);
    check("R4 iso held during ramp", 32'(iso[d]), 32'd1);
    repeat (c) idle();
    rd(A_STAT, r);
    check("R4 status still off before count ends", 32'(r[d]), 32'd1);
    check("R4 iso held at count end", 32'(iso[d]), 32'd1);
    rd(A_STAT, r);
    check("R4 status on after count", 32'(r[d]), 32'd0);
    check("R4 iso released one cycle after status", 32'(iso[d]), 32'd0);
  endtask

  initial begin
    logic [31:0] r;
    int unused_seed;
    unused_seed = $urandom(32'd7713);
    repeat (5) @(posedge clk);
    @(negedge clk);
    rst = 1'b0;

    // R1 reset state
    check("R1 sw_en after reset", {28'd0, sw_en}, exp_sw(4'd0));
    check("R1 iso after reset", {28'd0, iso}, exp_iso(4'd0));
    rd(A_CTRL, r);  check("R1 ctrl after reset", r, 32'd0);
    rd(A_STAT, r);  check("R1 status after reset", r, exp_stat(4'd0, bus_idle));
    rd(A_CDN, r);   check("R1 core down count", r, 32'd24);
    rd(A_CUP, r);   check("R1 core up count", r, 32'd24);
    rd(A_GDN, r);   check("R1 gfx down count", r, 32'd24);
    rd(A_GUP, r);   check("R1 gfx up count", r, 32'd24);

    // Default counts on a core domain
    run_down(1, cdn);
    run_up(1, cup);

    // R5 count programming and read-back
    cdn = 3; cup = 5; gdn = 2; gup = 0;
    wr(A_CDN, 32'hABCD_0003);
    wr(A_CUP, 32'd5);
    wr(A_GDN, 32'd2);
    wr(A_GUP, 32'd0);
    rd(A_CDN, r);  check("R5 core down read-back", r, 32'd3);
    rd(A_CUP, r);  check("R5 core up read-back", r, 32'd5);
    rd(A_GDN, r);  check("R5 gfx down read-back", r, 32'd2);
    rd(A_GUP, r);  check("R5 gfx up read-back", r, 32'd0);

    // R5 group pairing: core domain 0, graphics domain 2 (zero up count)
    run_down(0, cdn);
    run_up(0, cup);
    run_down(2, gdn);
    run_up(2, gup);

    // R8 register map
    wr(A_STAT, 32'hF);
    rd(A_STAT, r);  check("R8 status write ignored", r, exp_stat(ctrl_sh, bus_idle));
    rd(8'h20, r);   check("R8 unmapped reads zero", r, 32'd0);
    bus_idle = 4'b1010;
    rd(A_IDLE, r);  check("R8 idle mirror", r, 32'hA);

    // R6 domain without a switch
    wr(A_CTRL, 32'h8);
    rd(A_CTRL, r);  check("R6 no-switch ctrl bit ignored", r, 32'd0);
    repeat (12) idle();
    check("R6 no-switch sw_en", 32'(sw_en[3]), 32'd0);
    check("R6 no-switch iso", 32'(iso[3]), 32'd0);
    rd(A_STAT, r);  check("R6 status follows idle high", 32'(r[3]), 32'd1);
    bus_idle[3] = 1'b0;
    rd(A_STAT, r);  check("R6 status follows idle low", 32'(r[3]), 32'd0);
    check("R6 switched domains untouched", {28'd0, sw_en}, exp_sw(4'd0));

    // R7 request during a transition is deferred
    ctrl_sh = 4'b0001;
    wr(A_CTRL, 32'h1);
    idle();
    ctrl_sh = 4'b0000;
    wr(A_CTRL, 32'h0);
    check("R7 down continues after up request", 32'(sw_en[0]), 32'd0);
    repeat (cdn + 1) idle();
    check("R7 still off while completing", 32'(sw_en[0]), 32'd0);
    check("R7 iso held while completing", 32'(iso[0]), 32'd1);
    idle();
    check("R7 pending up applied next cycle", 32'(sw_en[0]), 32'd1);
    repeat (20) idle();
    check("R7 settled on", 32'(iso[0]), 32'd0);

    // Random phase: bursts of writes at random spacing, then settle and compare
    for (int round = 0; round < 10; round++) begin
      for (int k = 0; k < 6; k++) begin
        logic [3:0] v;
        v = 4'($urandom);
        bus_idle = 4'($urandom);
        ctrl_sh = v & SWM;
        wr(A_CTRL, {28'd0, v});
        repeat ($urandom_range(0, 12)) idle();
      end
      repeat (40) idle();
      check("R2 R4 random sw_en", {28'd0, sw_en}, exp_sw(ctrl_sh));
      check("R9 random iso", {28'd0, iso}, exp_iso(ctrl_sh));
      rd(A_STAT, r);  check("R3 random status", r, exp_stat(ctrl_sh, bus_idle));
      rd(A_CTRL, r);  check("R6 random ctrl", r, {28'd0, ctrl_sh});
    end

    done = 1'b1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      fails++;
      checks++;
      $display("FAIL watchdog actual=%h expected=%h", 32'd0, 32'd1);
      $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
      $finish;
    end
  end

endmodule